// File: doc/BRIEF.md
# Cache Performance Event Selector

This block sits between the instruction cache, the data cache and two general-purpose timer/counters. Each cycle the caches raise status strobes: misses, stalls, bank conflicts, copybacks, buffer-full, stream misses and prefetch outcomes. The block turns them into one increment pulse for each timer input. Software picks what each timer counts by writing a 4-bit event code per channel through a simple write port. Both codes sit in one control word.

Stall cycles are attributed with a precedence rule. A cycle in which both caches stall is credited to the instruction cache only. The data-cache stall event counts only the cycles in which the data cache stalls alone. The prefetch-discard events overlap on purpose: one code counts every discard, whatever the reason, and another counts only the discards caused by a cache hit. All status inputs and pulse outputs are plain level signals sampled every cycle. There is no valid/ready handshake and no back-pressure, because every cycle carries exactly one sample per input and the timers accept a pulse in any cycle.

Top module: `evsel_top`

## Requirements
- R1: After reset both selector fields are 0 and both `ev_tick` bits are low.
- R2: Code 0 never produces a pulse, whatever the status inputs are.
- R3: Code 1 follows `ic_miss`, code 3 follows `dc_bank_conflict`, code 4 follows `dc_rd_miss` and code 5 follows `dc_wr_miss`.
- R4: Code 2 pulses in every cycle with `ic_stall` high, including cycles in which `dc_stall` is also high.
- R5: Code 6 pulses only when `dc_stall` is high and `ic_stall` is low in the same cycle.
- R6: Code 7 follows `dc_copyback`, code 8 follows `dc_cb_full`, code 9 follows `dc_wr_miss_busy` and code 10 follows `dc_stream_miss`.
- R7: Code 11 follows `pf_kept`. Code 12 pulses when `pf_drop_hit` or `pf_drop_nofu` is high. Code 13 pulses only on `pf_drop_hit`.
- R8: Codes 14 and 15 never produce a pulse.
- R9: Each `ev_tick` bit is registered. It reflects the status inputs sampled at the previous rising clock edge, and it is high for one cycle per cycle in which the condition holds.
- R10: A write with `sel_we` high loads `sel_wdata[3:0]` into channel 0 and `sel_wdata[7:4]` into channel 1. The new code governs the pulse formed at the next clock edge after the write edge. The pulse formed at the write edge still uses the old code, so no pulse mixes the two codes.
- R11: When both channels hold the same code, both `ev_tick` bits are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the selector word |
| sel_wdata | input | 8 | Selector word: [3:0] channel 0, [7:4] channel 1 |
| ic_miss | input | 1 | Instruction-cache miss this cycle |
| ic_stall | input | 1 | Instruction cache stalling this cycle |
| dc_bank_conflict | input | 1 | Data-cache bank conflict |
| dc_rd_miss | input | 1 | Data-cache read miss |
| dc_wr_miss | input | 1 | Data-cache write miss |
| dc_stall | input | 1 | Data cache stalling this cycle |
| dc_copyback | input | 1 | Dirty line copied back to memory |
| dc_cb_full | input | 1 | Copyback buffer full |
| dc_wr_miss_busy | input | 1 | Write miss with every fetch unit occupied |
| dc_stream_miss | input | 1 | Data-cache stream miss |
| pf_kept | input | 1 | Prefetch started and not discarded |
| pf_drop_hit | input | 1 | Prefetch discarded because it hit |
| pf_drop_nofu | input | 1 | Prefetch discarded for lack of a fetch unit |
| ev_tick | output | 2 | Increment pulse per timer channel |

## Verification
Two functions can fall in the same clock edge: a selector write and a pulse driven by a live event. The bench holds an event high across the write edge while switching a channel to a code whose event is low. It expects the old code's pulse at the write edge and the new code's result one edge later. The stall precedence and the discard overlap are also provoked in a single cycle. The bench raises both stall strobes, or both discard reasons, together. A scoreboard then judges codes 2, 6, 12 and 13 side by side on the two channels.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int unsigned EV_CODE_W = 4;
  localparam int unsigned EV_NUM    = 1 << EV_CODE_W;

  typedef enum logic [EV_CODE_W-1:0] {
    EC_NONE      = 4'd0,
    EC_IC_MISS   = 4'd1,
    EC_IC_STALL  = 4'd2,
    EC_DC_BANK   = 4'd3,
    EC_DC_RMISS  = 4'd4,
    EC_DC_WMISS  = 4'd5,
    EC_DC_STALL  = 4'd6,
    EC_DC_CPBK   = 4'd7,
    EC_CB_FULL   = 4'd8,
    EC_WM_BUSY   = 4'd9,
    EC_STREAM    = 4'd10,
    EC_PF_KEPT   = 4'd11,
    EC_PF_DROP   = 4'd12,
    EC_PF_DHIT   = 4'd13
  } ev_code_e;

  typedef struct packed {
    logic ic_miss;
    logic ic_stall;
    logic dc_bank_conflict;
    logic dc_rd_miss;
    logic dc_wr_miss;
    logic dc_stall;
    logic dc_copyback;
    logic dc_cb_full;
    logic dc_wr_miss_busy;
    logic dc_stream_miss;
    logic pf_kept;
    logic pf_drop_hit;
    logic pf_drop_nofu;
  } cache_stat_t;
endpackage

// File: rtl/evsel_decode.sv
module evsel_decode
  import evsel_pkg::*;
#(
  parameter int unsigned N_EV = EV_NUM
) (
  input  cache_stat_t     stat,
  output logic [N_EV-1:0] ev_vec
);
  // Stall attribution: overlap goes to the instruction cache.
  logic dc_stall_alone;
  logic pf_any_drop;

  assign dc_stall_alone = stat.dc_stall & ~stat.ic_stall;
  assign pf_any_drop    = stat.pf_drop_hit | stat.pf_drop_nofu;

  always_comb begin
    ev_vec = '0;
    ev_vec[EC_IC_MISS]  = stat.ic_miss;
    ev_vec[EC_IC_STALL] = stat.ic_stall;
    ev_vec[EC_DC_BANK]  = stat.dc_bank_conflict;
    ev_vec[EC_DC_RMISS] = stat.dc_rd_miss;
    ev_vec[EC_DC_WMISS] = stat.dc_wr_miss;
    ev_vec[EC_DC_STALL] = dc_stall_alone;
    ev_vec[EC_DC_CPBK]  = stat.dc_copyback;
    ev_vec[EC_CB_FULL]  = stat.dc_cb_full;
    ev_vec[EC_WM_BUSY]  = stat.dc_wr_miss_busy;
    ev_vec[EC_STREAM]   = stat.dc_stream_miss;
    ev_vec[EC_PF_KEPT]  = stat.pf_kept;
    ev_vec[EC_PF_DROP]  = pf_any_drop;
    ev_vec[EC_PF_DHIT]  = stat.pf_drop_hit;
  end

  always_comb begin
    assert (!(ev_vec[EC_DC_STALL] && ev_vec[EC_IC_STALL]))
      else $error("p_stall_exclusive_r5");
    assert (!ev_vec[EC_PF_DHIT] || ev_vec[EC_PF_DROP])
      else $error("p_hit_within_drop_r7");
  end
endmodule

// File: rtl/evsel_chan.sv
module evsel_chan #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned N_EV = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [SEL_W-1:0] ld_code,
  input  logic [N_EV-1:0]  ev_vec,
  output logic [SEL_W-1:0] code_q,
  output logic             tick
);
  logic past_ok;

  // The pulse at an edge uses the code held before that edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      tick    <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      tick    <= ev_vec[code_q];
      past_ok <= 1'b1;
      if (ld) code_q <= ld_code;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(code_q) == '0) |-> !tick);

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(code_q) >= SEL_W'(14)) |-> !tick);

  p_load_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> code_q == $past(ld_code));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ld) |=> $stable(code_q));
endmodule

// File: rtl/evsel_top.sv
module evsel_top
  import evsel_pkg::*;
#(
  parameter int unsigned N_CH  = 2,
  parameter int unsigned SEL_W = EV_CODE_W,
  localparam int unsigned N_EV = 1 << SEL_W,
  localparam int unsigned WD_W = N_CH * SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [WD_W-1:0] sel_wdata,
  input  logic            ic_miss,
  input  logic            ic_stall,
  input  logic            dc_bank_conflict,
  input  logic            dc_rd_miss,
  input  logic            dc_wr_miss,
  input  logic            dc_stall,
  input  logic            dc_copyback,
  input  logic            dc_cb_full,
  input  logic            dc_wr_miss_busy,
  input  logic            dc_stream_miss,
  input  logic            pf_kept,
  input  logic            pf_drop_hit,
  input  logic            pf_drop_nofu,
  output logic [N_CH-1:0] ev_tick
);
  cache_stat_t            stat;
  logic [N_EV-1:0]        ev_vec;
  logic [SEL_W-1:0]       code_q [N_CH];
  logic                   past_ok;

  always_comb begin
    stat.ic_miss          = ic_miss;
    stat.ic_stall         = ic_stall;
    stat.dc_bank_conflict = dc_bank_conflict;
    stat.dc_rd_miss       = dc_rd_miss;
    stat.dc_wr_miss       = dc_wr_miss;
    stat.dc_stall         = dc_stall;
    stat.dc_copyback      = dc_copyback;
    stat.dc_cb_full       = dc_cb_full;
    stat.dc_wr_miss_busy  = dc_wr_miss_busy;
    stat.dc_stream_miss   = dc_stream_miss;
    stat.pf_kept          = pf_kept;
    stat.pf_drop_hit      = pf_drop_hit;
    stat.pf_drop_nofu     = pf_drop_nofu;
  end

  evsel_decode #(.N_EV(N_EV)) u_dec (
    .stat   (stat),
    .ev_vec (ev_vec)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    evsel_chan #(.SEL_W(SEL_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (sel_we),
      .ld_code (sel_wdata[c*SEL_W +: SEL_W]),
      .ev_vec  (ev_vec),
      .code_q  (code_q[c]),
      .tick    (ev_tick[c])
    );

    p_ic_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(code_q[c]) == SEL_W'(2) && $past(ic_stall)) |-> ev_tick[c]);

    p_dc_stall_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(code_q[c]) == SEL_W'(6) && $past(ic_stall)) |-> !ev_tick[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  if (N_CH >= 2) begin : g_pair_chk
    p_same_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(code_q[0]) == $past(code_q[1])) |-> ev_tick[0] == ev_tick[1]);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> ev_tick == '0);
endmodule

// File: tb/sim_evsel_top.sv
module sim_evsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [7:0]  sel_wdata = '0;
  logic [12:0] st = '0;
  logic [1:0]  ev_tick;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  logic [3:0] m0 = '0, m1 = '0;

  always #4ns clk = ~clk;

  evsel_top u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .ic_miss(st[0]), .ic_stall(st[1]), .dc_bank_conflict(st[2]),
    .dc_rd_miss(st[3]), .dc_wr_miss(st[4]), .dc_stall(st[5]),
    .dc_copyback(st[6]), .dc_cb_full(st[7]), .dc_wr_miss_busy(st[8]),
    .dc_stream_miss(st[9]), .pf_kept(st[10]), .pf_drop_hit(st[11]),
    .pf_drop_nofu(st[12]), .ev_tick(ev_tick)
  );

  function automatic logic want(input logic [3:0] code, input logic [12:0] s);
    case (code)
      4'd1:  return s[0];
      4'd2:  return s[1];
      4'd3:  return s[2];
      4'd4:  return s[3];
      4'd5:  return s[4];
      4'd6:  return s[5] & ~s[1];
      4'd7:  return s[6];
      4'd8:  return s[7];
      4'd9:  return s[8];
      4'd10: return s[9];
      4'd11: return s[10];
      4'd12: return s[11] | s[12];
      4'd13: return s[11];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    case (code)
      4'd0: return "R2";
      4'd1, 4'd3, 4'd4, 4'd5: return "R3";
      4'd2: return "R4";
      4'd6: return "R5";
      4'd7, 4'd8, 4'd9, 4'd10: return "R6";
      4'd11, 4'd12, 4'd13: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: one call per cycle; expected result lands one edge later (R9).
  task automatic step(input logic [12:0] s, input bit we, input logic [7:0] wd,
                      input string extra);
    item_t it;
    @(negedge clk);
    st = s; sel_we = we; sel_wdata = wd;
    it.exp = {want(m1, s), want(m0, s)};
    it.tag = (extra != "") ? extra : ((m0 == m1) ? {tag_of(m0), "/R11"} : {tag_of(m0), "/", tag_of(m1)});
    q.push_back(it);
    if (we) begin
      m0 = wd[3:0];
      m1 = wd[7:4];
    end
  endtask

  // Monitor: compares away from the edge.
  always @(posedge clk) begin
    #2ns;
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (ev_tick !== it.exp) begin
        failures++;
        $display("FAIL %s R9 ev_tick actual=%b expected=%b", it.tag, ev_tick, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    st = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (ev_tick !== 2'b00) begin
      failures++;
      $display("FAIL R1 ev_tick in reset actual=%b expected=00", ev_tick);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R2: selectors start at 0, all events live gives no pulse
    step('1, 0, '0, "R1/R2");
    step('1, 0, '0, "R1/R2");
    // Sweep every code on both channels with single and overlapping inputs
    for (int c = 0; c < 16; c++) begin
      step('0, 1, {c[3:0], c[3:0]}, "R10");
      for (int b = 0; b < 13; b++) step(13'(1) << b, 0, '0, "");
      step(13'b0_0000_0010_0010, 0, '0, "");  // both stalls (R4/R5)
      step(13'b0_0000_0010_0000, 0, '0, "");  // data stall alone
      step(13'b1_1000_0000_0000, 0, '0, "");  // both drop reasons (R7)
      step(13'b1_0000_0000_0000, 0, '0, "");  // drop, no fetch unit only
      step('1, 0, '0, "");
      step('0, 0, '0, "");
    end
    // R4/R5 on distinct channels in the same cycle
    step('0, 1, {4'd6, 4'd2}, "R10");
    step(13'b0_0000_0010_0010, 0, '0, "R4/R5 overlap");
    step(13'b0_0000_0010_0000, 0, '0, "R4/R5 dc alone");
    step(13'b0_0000_0000_0010, 0, '0, "R4/R5 ic alone");
    // R7 on distinct channels
    step('0, 1, {4'd13, 4'd12}, "R10");
    step(13'b1_0000_0000_0000, 0, '0, "R7 nofu");
    step(13'b0_1000_0000_0000, 0, '0, "R7 hit");
    // R10: switch with live event on the write edge
    step('0, 1, {4'd1, 4'd1}, "R10");
    step(13'b0_0000_0000_0001, 0, '0, "R10 before");
    step(13'b0_0000_0000_0001, 1, {4'd4, 4'd1}, "R10 write edge old code");
    step(13'b0_0000_0000_0001, 0, '0, "R10 new code");
    step(13'b0_0000_0000_1000, 1, {4'd1, 4'd4}, "R10 write edge swap");
    step(13'b0_0000_0000_1000, 0, '0, "R10 after swap");
    step('0, 0, '0, "R10 flush");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule